// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller

This block connects an on-chip request stream to one external asynchronous SRAM or NOR flash device. The device has a 16-bit data bus and a 24-bit address bus. Every bus cycle passes through three phases: setup, strobe and hold. Reads and writes each have their own programmable length for every phase. A request is either narrow (one 16-bit bus cycle) or wide (a 32-bit transfer that the block splits into two bus cycles at consecutive addresses). Chip select stays low while requests follow one another. It rises only when the bus goes idle. A programmable number of turnaround cycles separates two distinct requests. The two halves of a split request run back to back with no turnaround between them.

The request side is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is high while the controller is idle, and also in the last hold cycle of the final bus cycle of the request in flight. In every other cycle it is low, and a requester must hold its request stable until it is taken. Read data comes back with a single-cycle `rsp_valid` pulse. This pulse has no back-pressure, so the requester must always be able to take it. The timing fields are plain control inputs and are expected to stay static while the bus is active. The data bus is presented as separate output, per-lane output-enable and input pins, and a pad ring combines them into the tri-state pins.

Top module: `async_mem_ctrl`

## Requirements
- R1: During and after reset, with no request pending, chip select, output enable, write enable and both byte enables are high, the address is zero, no data lane is driven, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read bus cycle drives chip select low, both byte enables low and the address valid for setup field + 1 cycles. Output enable is then low for strobe field + 1 cycles. Hold follows for hold field + 1 cycles with output enable high. A field of zero gives a one-cycle phase.
- R3: A write bus cycle uses the three write timing fields in the same way. Write enable is low exactly during the strobe phase, and output enable stays high for the whole bus cycle.
- R4: On a write, request byte-enable bit 0 selects data lane 7:0 and bit 1 selects lane 15:8, both active high. For each selected lane, the external byte enable (bit i of `mem_be_n`, active low) is low and `mem_dq_oe[i]` is 1 through setup, strobe and hold, with `mem_dq_o` carrying that lane's write data. Unselected lanes have their byte enable high and are not driven.
- R5: No data lane is driven at any point of a read bus cycle.
- R6: Read data is sampled from `mem_dq_i` on the clock edge that ends strobe. `rsp_valid` is 1 for exactly the first hold cycle of the request's final bus cycle. A narrow read returns the word in `rsp_rdata[15:0]` with bits 31:16 zero.
- R7: A wide request (`req_wide` = 1) makes two bus cycles: first at `req_addr` using data bits 15:0 and byte enables 1:0, then at `req_addr` + 1 using data bits 31:16 and byte enables 3:2. The second setup starts in the cycle right after the first hold, with chip select still low. A wide read returns the second word in bits 31:16 and the first word in bits 15:0.
- R8: If no request is valid in the last hold cycle, chip select and both byte enables go high and the address returns to zero in the next cycle.
- R9: If a request is valid in the last hold cycle, it is taken at that edge and chip select stays low. The bus then spends `cfg_turn` cycles with byte enables, output enable and write enable high, no lane driven and the address zero, and then enters setup. With `cfg_turn` = 0 it enters setup directly.
- R10: `req_ready` is 0 from the cycle after a request is taken until the last hold cycle of its final bus cycle, and it is 1 in that last hold cycle.
- R11: Output enable and write enable are never low together, and no data lane is driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit transfer split into two bus cycles |
| req_addr | input | 24 | 16-bit word address of the first bus cycle |
| req_be | input | 4 | Active-high byte enables, two per bus cycle |
| req_wdata | input | 32 | Write data, low half first |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 32 | Returned read data |
| cfg_rd_setup | input | 4 | Read setup length minus one |
| cfg_rd_strobe | input | 4 | Read strobe length minus one |
| cfg_rd_hold | input | 4 | Read hold length minus one |
| cfg_wr_setup | input | 4 | Write setup length minus one |
| cfg_wr_strobe | input | 4 | Write strobe length minus one |
| cfg_wr_hold | input | 4 | Write hold length minus one |
| cfg_turn | input | 3 | Turnaround cycles between distinct requests |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte enables, active low, bit i for lane i |
| mem_addr | output | 24 | Device address |
| mem_dq_o | output | 16 | Data driven toward the device |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned by the device |

## Verification
The bench goes after the one-cycle phases from zero fields. A controller that loads its counters without the extra count would collapse or skip a phase, and the cycle-by-cycle pin comparison would catch it. It runs wide reads and writes and checks that the second bus cycle follows the first hold immediately at the next address. A design that inserted turnaround there, or sliced the wrong halves, would shift the pins or swap the returned words. It runs back-to-back requests with a non-zero and a zero turnaround count. A design that released chip select between them, or miscounted turnaround, would show chip select high or setup in the wrong cycle. Single-lane writes confirm that the opposite lane stays undriven with its byte enable high. A design that ignored byte enables would drive both lanes.

// File: rtl/amc_pkg.sv
package amc_pkg;

  typedef enum logic [2:0] {
    AMC_IDLE   = 3'd0,
    AMC_SETUP  = 3'd1,
    AMC_STROBE = 3'd2,
    AMC_HOLD   = 3'd3,
    AMC_TURN   = 3'd4
  } amc_phase_e;

endpackage

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int PH_W = 4,
  parameter int TA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            op_write,
  input  logic            last_beat,
  input  logic [PH_W-1:0] rd_setup,
  input  logic [PH_W-1:0] rd_strobe,
  input  logic [PH_W-1:0] rd_hold,
  input  logic [PH_W-1:0] wr_setup,
  input  logic [PH_W-1:0] wr_strobe,
  input  logic [PH_W-1:0] wr_hold,
  input  logic [TA_W-1:0] turn_len,
  output amc_phase_e      phase_o,
  output logic            take_o,
  output logic            beat_adv_o,
  output logic            cap_o
);

  localparam int CNT_W = (PH_W > TA_W) ? PH_W : TA_W;

  amc_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic [PH_W-1:0]  new_setup, cur_setup, cur_strobe, cur_hold;

  assign cnt_zero   = (cnt_q == '0);
  // timing fields for a request being taken now versus the one in flight
  assign new_setup  = req_write ? wr_setup  : rd_setup;
  assign cur_setup  = op_write  ? wr_setup  : rd_setup;
  assign cur_strobe = op_write  ? wr_strobe : rd_strobe;
  assign cur_hold   = op_write  ? wr_hold   : rd_hold;

  assign take_o = (phase_q == AMC_IDLE) ||
                  (phase_q == AMC_HOLD && cnt_zero && last_beat);

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    beat_adv_o = 1'b0;
    cap_o      = 1'b0;
    unique case (phase_q)
      AMC_IDLE: begin
        if (req_valid) begin
          phase_d = AMC_SETUP;
          cnt_d   = CNT_W'(new_setup);
        end
      end
      AMC_SETUP: begin
        if (cnt_zero) begin
          phase_d = AMC_STROBE;
          cnt_d   = CNT_W'(cur_strobe);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      AMC_STROBE: begin
        if (cnt_zero) begin
          phase_d = AMC_HOLD;
          cnt_d   = CNT_W'(cur_hold);
          cap_o   = !op_write;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      AMC_HOLD: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (!last_beat) begin
          phase_d    = AMC_SETUP;
          cnt_d      = CNT_W'(cur_setup);
          beat_adv_o = 1'b1;
        end else if (req_valid) begin
          if (turn_len == '0) begin
            phase_d = AMC_SETUP;
            cnt_d   = CNT_W'(new_setup);
          end else begin
            phase_d = AMC_TURN;
            cnt_d   = CNT_W'(turn_len) - CNT_W'(1);
          end
        end else begin
          phase_d = AMC_IDLE;
        end
      end
      AMC_TURN: begin
        if (cnt_zero) begin
          phase_d = AMC_SETUP;
          cnt_d   = CNT_W'(cur_setup);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        phase_d = AMC_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= AMC_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;

  // R9: turnaround always hands over to setup, never to idle or hold
  a_r9_turn_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == AMC_TURN && phase_d != AMC_TURN) |=> (phase_q == AMC_SETUP));

  // R2: strobe is only entered from setup
  a_r2_strobe_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == AMC_STROBE) |-> ($past(phase_q) == AMC_SETUP));

endmodule

// File: rtl/amc_beat_path.sv
module amc_beat_path #(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16,
  parameter int REQ_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   beat_adv,
  input  logic                   req_write,
  input  logic                   req_wide,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [REQ_W/8-1:0]     req_be,
  input  logic [REQ_W-1:0]       req_wdata,
  output logic                   op_write,
  output logic                   last_beat,
  output logic [((REQ_W/BUS_W) > 1 ? $clog2(REQ_W/BUS_W) : 1)-1:0] beat_idx,
  output logic [ADDR_W-1:0]      beat_addr,
  output logic [BUS_W/8-1:0]     beat_be,
  output logic [BUS_W-1:0]       beat_wdata
);

  localparam int BEATS  = REQ_W / BUS_W;
  localparam int LANES  = BUS_W / 8;
  localparam int BIDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              wr_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REQ_W/8-1:0] be_q;
  logic [REQ_W-1:0]  wd_q;
  logic [BIDX_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      beat_q <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      wide_q <= req_wide;
      addr_q <= req_addr;
      be_q   <= req_be;
      wd_q   <= req_wdata;
      beat_q <= '0;
    end else if (beat_adv) begin
      beat_q <= beat_q + BIDX_W'(1);
    end
  end

  assign op_write   = wr_q;
  assign beat_idx   = beat_q;
  assign last_beat  = !wide_q || (beat_q == BIDX_W'(BEATS - 1));
  assign beat_addr  = addr_q + ADDR_W'(beat_q);
  assign beat_be    = be_q[int'(beat_q)*LANES +: LANES];
  assign beat_wdata = wd_q[int'(beat_q)*BUS_W +: BUS_W];

  // R7: a narrow request never leaves its first bus cycle
  a_r7_narrow_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (beat_q == '0));

  // R7: the beat only advances while the request is wide
  a_r7_adv_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv |-> wide_q);

endmodule

// File: rtl/amc_pin_drive.sv
module amc_pin_drive
  import amc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16
) (
  input  amc_phase_e         phase,
  input  logic               op_write,
  input  logic [ADDR_W-1:0]  beat_addr,
  input  logic [BUS_W/8-1:0] beat_be,
  input  logic [BUS_W-1:0]   beat_wdata,
  output logic               cs_n,
  output logic               oe_n,
  output logic               we_n,
  output logic [BUS_W/8-1:0] be_n,
  output logic [ADDR_W-1:0]  addr,
  output logic [BUS_W-1:0]   dq_o,
  output logic [BUS_W/8-1:0] dq_oe
);

  localparam int LANES = BUS_W / 8;

  logic in_cycle;

  assign in_cycle = (phase == AMC_SETUP) || (phase == AMC_STROBE) ||
                    (phase == AMC_HOLD);
  assign cs_n = !(in_cycle || phase == AMC_TURN);
  assign oe_n = !(phase == AMC_STROBE && !op_write);
  assign we_n = !(phase == AMC_STROBE && op_write);
  assign addr = in_cycle ? beat_addr : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    assign lane_on           = op_write ? beat_be[g] : 1'b1;
    assign be_n[g]           = !(in_cycle && lane_on);
    assign dq_oe[g]          = in_cycle && op_write && beat_be[g];
    assign dq_o[g*8 +: 8]    = dq_oe[g] ? beat_wdata[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/amc_rd_gather.sv
module amc_rd_gather #(
  parameter int BUS_W = 16,
  parameter int REQ_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             cap,
  input  logic             last_beat,
  input  logic [((REQ_W/BUS_W) > 1 ? $clog2(REQ_W/BUS_W) : 1)-1:0] beat_idx,
  input  logic [BUS_W-1:0] dq_i,
  output logic             rsp_valid,
  output logic [REQ_W-1:0] rsp_data
);

  localparam int BEATS  = REQ_W / BUS_W;
  localparam int BIDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [REQ_W-1:0] data_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= '0;
    end else if (cap) begin
      for (int b = 0; b < BEATS; b++) begin
        if (beat_idx == BIDX_W'(b)) data_q[b*BUS_W +: BUS_W] <= dq_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= cap && last_beat;
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;

  // R6: the response is a single-cycle pulse
  a_r6_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R6: no response without a capture in the previous cycle
  a_r6_rsp_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(cap));

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl
  import amc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BUS_W  = 16,
  parameter int REQ_W  = 32,
  parameter int PH_W   = 4,
  parameter int TA_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_wide,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [REQ_W/8-1:0] req_be,
  input  logic [REQ_W-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic [REQ_W-1:0]   rsp_rdata,
  input  logic [PH_W-1:0]    cfg_rd_setup,
  input  logic [PH_W-1:0]    cfg_rd_strobe,
  input  logic [PH_W-1:0]    cfg_rd_hold,
  input  logic [PH_W-1:0]    cfg_wr_setup,
  input  logic [PH_W-1:0]    cfg_wr_strobe,
  input  logic [PH_W-1:0]    cfg_wr_hold,
  input  logic [TA_W-1:0]    cfg_turn,
  output logic               mem_cs_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [BUS_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BUS_W-1:0]   mem_dq_o,
  output logic [BUS_W/8-1:0] mem_dq_oe,
  input  logic [BUS_W-1:0]   mem_dq_i
);

  localparam int BEATS  = REQ_W / BUS_W;
  localparam int LANES  = BUS_W / 8;
  localparam int BIDX_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  amc_phase_e        phase;
  logic              take, accept, beat_adv, cap;
  logic              op_write, last_beat;
  logic [BIDX_W-1:0] beat_idx;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANES-1:0]  beat_be;
  logic [BUS_W-1:0]  beat_wdata;

  assign req_ready = take;
  assign accept    = req_valid && take;

  amc_seq #(.PH_W(PH_W), .TA_W(TA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .op_write   (op_write),
    .last_beat  (last_beat),
    .rd_setup   (cfg_rd_setup),
    .rd_strobe  (cfg_rd_strobe),
    .rd_hold    (cfg_rd_hold),
    .wr_setup   (cfg_wr_setup),
    .wr_strobe  (cfg_wr_strobe),
    .wr_hold    (cfg_wr_hold),
    .turn_len   (cfg_turn),
    .phase_o    (phase),
    .take_o     (take),
    .beat_adv_o (beat_adv),
    .cap_o      (cap)
  );

  amc_beat_path #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .REQ_W(REQ_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .beat_adv   (beat_adv),
    .req_write  (req_write),
    .req_wide   (req_wide),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .op_write   (op_write),
    .last_beat  (last_beat),
    .beat_idx   (beat_idx),
    .beat_addr  (beat_addr),
    .beat_be    (beat_be),
    .beat_wdata (beat_wdata)
  );

  amc_pin_drive #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_pins (
    .phase      (phase),
    .op_write   (op_write),
    .beat_addr  (beat_addr),
    .beat_be    (beat_be),
    .beat_wdata (beat_wdata),
    .cs_n       (mem_cs_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .be_n       (mem_be_n),
    .addr       (mem_addr),
    .dq_o       (mem_dq_o),
    .dq_oe      (mem_dq_oe)
  );

  amc_rd_gather #(.BUS_W(BUS_W), .REQ_W(REQ_W)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cap       (cap),
    .last_beat (last_beat),
    .beat_idx  (beat_idx),
    .dq_i      (mem_dq_i),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata)
  );

  // R11: output and write strobes are mutually exclusive
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R11: the controller never drives data while the device may
  a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_dq_oe) |-> mem_oe_n);

  // R4: during the write strobe the driven lanes are exactly the enabled bytes
  a_r4_lane_match: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe == ~mem_be_n));

  // R8: chip select is only released after a hold phase
  a_r8_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> ($past(phase) == AMC_HOLD));

  // R2: address is settled before output enable falls
  a_r2_addr_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $stable(mem_addr));

  // R9: a request taken at the end of hold keeps chip select low
  a_r9_cs_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && phase == AMC_HOLD) |=> !mem_cs_n);

endmodule

// File: tb/async_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module async_mem_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  cfg_rd_setup = '0, cfg_rd_strobe = '0, cfg_rd_hold = '0;
  logic [3:0]  cfg_wr_setup = '0, cfg_wr_strobe = '0, cfg_wr_hold = '0;
  logic [2:0]  cfg_turn = '0;
  logic        mem_cs_n, mem_oe_n, mem_we_n;
  logic [1:0]  mem_be_n;
  logic [23:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic [1:0]  mem_dq_oe;
  logic [15:0] mem_dq_i;

  logic [15:0] model [0:63];
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign mem_dq_i = (!mem_cs_n && !mem_oe_n) ? model[mem_addr[5:0]] : 16'h0000;

  async_mem_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_turn(cfg_turn),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compares {cs,oe,we,be_n,addr,dq_oe,rsp_valid,req_ready} in the current cycle
  task automatic cyc(input string req, input string what,
                     input logic cs, input logic oe, input logic we,
                     input logic [1:0] ben, input logic [23:0] a,
                     input logic [1:0] dqoe, input logic rsp, input logic rdy);
    chk_eq(req, what,
           {31'd0, mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_addr, mem_dq_oe, rsp_valid, req_ready},
           {31'd0, cs, oe, we, ben, a, dqoe, rsp, rdy});
  endtask

  task automatic chk_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(req, "idle", 1'b1, 1'b1, 1'b1, 2'b11, 24'd0, 2'b00, 1'b0, 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic chk_turn(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(req, "turnaround", 1'b0, 1'b1, 1'b1, 2'b11, 24'd0, 2'b00, 1'b0, 1'b0);
      @(negedge clk);
    end
  endtask

  // entered at the first setup negedge, leaves at the negedge after the last hold
  task automatic chk_beat(input string req, input logic w, input logic [23:0] a,
                          input logic [1:0] be, input logic [15:0] dout,
                          input logic rsp_exp, input logic [31:0] rsp_data,
                          input logic final_beat, input int s, input int t, input int h);
    logic [1:0]  ben  = w ? ~be : 2'b00;
    logic [1:0]  dqoe = w ? be : 2'b00;
    logic [15:0] mask = {{8{be[1]}}, {8{be[0]}}};
    for (int i = 0; i <= s; i++) begin
      cyc(req, "setup", 1'b0, 1'b1, 1'b1, ben, a, dqoe, 1'b0, 1'b0);
      @(negedge clk);
    end
    for (int i = 0; i <= t; i++) begin
      cyc(req, "strobe", 1'b0, w, !w, ben, a, dqoe, 1'b0, 1'b0);
      if (w && i == 0) chk_eq(req, "write data", {48'd0, mem_dq_o & mask}, {48'd0, dout & mask});
      @(negedge clk);
    end
    for (int i = 0; i <= h; i++) begin
      cyc(req, "hold", 1'b0, 1'b1, 1'b1, ben, a, dqoe,
          rsp_exp && (i == 0), final_beat && (i == h));
      if (rsp_exp && i == 0) chk_eq(req, "read data", {32'd0, rsp_rdata}, {32'd0, rsp_data});
      @(negedge clk);
    end
  endtask

  task automatic issue(input logic w, input logic wide, input logic [23:0] a,
                       input logic [3:0] be, input logic [31:0] wd);
    req_write = w; req_wide = wide; req_addr = a; req_be = be; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cyc("R1", "in reset", 1'b1, 1'b1, 1'b1, 2'b11, 24'd0, 2'b00, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1", 2);
  endtask

  task automatic t_read_basic;
    cfg_rd_setup = 4'd1; cfg_rd_strobe = 4'd2; cfg_rd_hold = 4'd0;
    issue(1'b0, 1'b0, 24'd5, 4'b0000, 32'd0);
    req_valid = 1'b0;
    chk_beat("R2 R5 R6", 1'b0, 24'd5, 2'b00, 16'd0, 1'b1, {16'd0, model[5]}, 1'b1, 1, 2, 0);
    chk_idle("R8", 2);
  endtask

  task automatic t_read_zero;
    cfg_rd_setup = 4'd0; cfg_rd_strobe = 4'd0; cfg_rd_hold = 4'd0;
    issue(1'b0, 1'b0, 24'd7, 4'b0000, 32'd0);
    req_valid = 1'b0;
    chk_beat("R2 R6", 1'b0, 24'd7, 2'b00, 16'd0, 1'b1, {16'd0, model[7]}, 1'b1, 0, 0, 0);
    chk_idle("R8", 1);
  endtask

  task automatic t_write_full;
    cfg_wr_setup = 4'd0; cfg_wr_strobe = 4'd1; cfg_wr_hold = 4'd2;
    issue(1'b1, 1'b0, 24'd9, 4'b0011, 32'h0000_1234);
    req_valid = 1'b0;
    chk_beat("R3 R4", 1'b1, 24'd9, 2'b11, 16'h1234, 1'b0, 32'd0, 1'b1, 0, 1, 2);
    chk_idle("R8", 1);
  endtask

  task automatic t_write_lanes;
    cfg_wr_setup = 4'd2; cfg_wr_strobe = 4'd0; cfg_wr_hold = 4'd1;
    issue(1'b1, 1'b0, 24'd20, 4'b0001, 32'h0000_ABCD);
    req_valid = 1'b0;
    chk_beat("R4 low lane", 1'b1, 24'd20, 2'b01, 16'hABCD, 1'b0, 32'd0, 1'b1, 2, 0, 1);
    chk_idle("R4", 1);
    issue(1'b1, 1'b0, 24'd21, 4'b0010, 32'h0000_9876);
    req_valid = 1'b0;
    chk_beat("R4 high lane", 1'b1, 24'd21, 2'b10, 16'h9876, 1'b0, 32'd0, 1'b1, 2, 0, 1);
    chk_idle("R4", 1);
  endtask

  task automatic t_wide_read;
    cfg_rd_setup = 4'd0; cfg_rd_strobe = 4'd1; cfg_rd_hold = 4'd1;
    issue(1'b0, 1'b1, 24'd10, 4'b1111, 32'd0);
    req_valid = 1'b0;
    chk_beat("R7 first", 1'b0, 24'd10, 2'b00, 16'd0, 1'b0, 32'd0, 1'b0, 0, 1, 1);
    chk_beat("R7 second", 1'b0, 24'd11, 2'b00, 16'd0, 1'b1, {model[11], model[10]}, 1'b1, 0, 1, 1);
    chk_idle("R8", 1);
  endtask

  task automatic t_wide_write;
    cfg_wr_setup = 4'd1; cfg_wr_strobe = 4'd0; cfg_wr_hold = 4'd0;
    issue(1'b1, 1'b1, 24'd30, 4'b0110, 32'h5566_7788);
    req_valid = 1'b0;
    chk_beat("R7 R4 first", 1'b1, 24'd30, 2'b10, 16'h7788, 1'b0, 32'd0, 1'b0, 1, 0, 0);
    chk_beat("R7 R4 second", 1'b1, 24'd31, 2'b01, 16'h5566, 1'b0, 32'd0, 1'b1, 1, 0, 0);
    chk_idle("R8", 1);
  endtask

  task automatic t_b2b_turn;
    cfg_turn = 3'd2;
    cfg_rd_setup = 4'd0; cfg_rd_strobe = 4'd0; cfg_rd_hold = 4'd1;
    cfg_wr_setup = 4'd0; cfg_wr_strobe = 4'd0; cfg_wr_hold = 4'd0;
    issue(1'b0, 1'b0, 24'd3, 4'b0000, 32'd0);
    issue_pending(1'b1, 1'b0, 24'd4, 4'b0011, 32'h0000_BEEF);
    chk_beat("R9 R10", 1'b0, 24'd3, 2'b00, 16'd0, 1'b1, {16'd0, model[3]}, 1'b1, 0, 0, 1);
    req_valid = 1'b0;
    chk_turn("R9", 2);
    chk_beat("R9", 1'b1, 24'd4, 2'b11, 16'hBEEF, 1'b0, 32'd0, 1'b1, 0, 0, 0);
    chk_idle("R8", 1);
  endtask

  task automatic t_b2b_noturn;
    cfg_turn = 3'd0;
    cfg_rd_setup = 4'd1; cfg_rd_strobe = 4'd0; cfg_rd_hold = 4'd0;
    issue(1'b0, 1'b0, 24'd12, 4'b0000, 32'd0);
    issue_pending(1'b0, 1'b0, 24'd13, 4'b0000, 32'd0);
    chk_beat("R9 R10", 1'b0, 24'd12, 2'b00, 16'd0, 1'b1, {16'd0, model[12]}, 1'b1, 1, 0, 0);
    req_valid = 1'b0;
    chk_beat("R9 zero turn", 1'b0, 24'd13, 2'b00, 16'd0, 1'b1, {16'd0, model[13]}, 1'b1, 1, 0, 0);
    chk_idle("R8", 1);
  endtask

  // loads the next request while the current one is in flight, without waiting
  task automatic issue_pending(input logic w, input logic wide, input logic [23:0] a,
                               input logic [3:0] be, input logic [31:0] wd);
    req_write = w; req_wide = wide; req_addr = a; req_be = be; req_wdata = wd;
    req_valid = 1'b1;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hA500 ^ 16'(i * 16'h0137);
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_read_zero();
    t_write_full();
    t_write_lanes();
    t_wide_read();
    t_wide_write();
    t_b2b_turn();
    t_b2b_noturn();
    finish_run();
  end

  initial begin
    #(5ns * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule